// File: doc/BRIEF.md
# Serial Management Control-Register Slave

This block is the management side of a fast Ethernet transceiver. It samples the serial management data line on rising edges of the management clock and finds frames in the line. It decodes the read and write frames addressed to it. It holds two writable registers: a basic control register at address 0 and a vendor control register at address 16. Their bits are combined with strap and control pins to produce the chip-level reset, power-down, isolate and coding-bypass controls. On a read it takes over the shared data line through an output enable, for the second turnaround bit and the sixteen data bits.

Frames use the common serial management layout. A preamble of at least 32 ones comes first, then start `01`. The opcode follows (`10` read, `01` write), then a 5-bit PHY address and a 5-bit register address, both MSB first. Two turnaround bits and 16 data bits, MSB first, complete the frame. The block answers its strap address and also always answers address `00000`. It keeps serving frames while powered down, isolated or in its reset sequence. Each pin control is ORed with the matching register bit.

Frame states:
- `FR_PRE` counts preamble ones.
- `FR_START` expects the `1` of the start pattern.
- `FR_OP` collects two opcode bits.
- `FR_PHY` and `FR_REG` shift in the addresses.
- `FR_TA1` and `FR_TA2` are the turnaround.
- `FR_DATA` moves 16 data bits.

Frame transitions:
- `FR_PRE`→`FR_START` on a 0 after 32 or more ones.
- `FR_START`→`FR_OP` on 1, otherwise back to `FR_PRE`.
- `FR_OP`→`FR_PHY` on a valid opcode, otherwise back to `FR_PRE`.
- `FR_PHY`→`FR_REG`→`FR_TA1`→`FR_TA2`→`FR_DATA`→`FR_PRE` after the fixed bit counts.

Reset-sequence states:
- `RS_BUSY` holds the chip in reset.
- `RS_READY` is normal operation.

Reset-sequence transitions:
- `RS_BUSY`→`RS_READY` when the sequence counter expires.
- `RS_READY`→`RS_BUSY` on a write that sets control bit 15.

Top module: `mgmt_ctrl_slave`

## Requirements
- R1: A frame is decoded only after 32 or more consecutive ones followed by `0`,`1`. Opcode `10` is a read and `01` a write. Any other opcode, or a shorter preamble, leaves every register and the data line untouched.
- R2: A frame is accepted when its PHY address equals `strap_phy` or equals `00000`. For any other address, no register changes and `mdio_oe` stays low.
- R3: On an accepted read, `mdio_oe` is low for the first turnaround bit. During the second turnaround bit it is high with `mdio_out` = 0. The 16 data bits then follow MSB first. Each bit changes after a rising `mdc` edge and stays valid for a full clock.
- R4: Register 0 and register 16 store all written bits except control bit 15. A read returns the stored value.
- R5: A read of any other register address returns 0. A write to it changes nothing.
- R6: Holding `rst_n` low, or writing 1 to control bit 15, starts a reset sequence. After the write, `chip_reset` is high for exactly `RST_CYCLES` clocks. Control bit 15 reads 1 while the sequence runs and 0 afterwards. At the end, both registers return to defaults (register 16 becomes 0).
- R7: At the end of every reset sequence, control bit 10 (isolate) takes the level of `strap_iso_def`. All other control bits become 0.
- R8: `pdown` = control bit 11 OR `pin_pdown`.
- R9: `iso` = control bit 10 OR `pin_iso`. While `iso` is high, every `data_oe` bit is 0. Otherwise `data_oe` follows `data_oe_req`.
- R10: `bypass` = (register-16 bit 1 OR `pin_bypass`) AND `mode_100`.
- R11: Reads and writes work normally while `pdown` or `iso` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; line sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset pin |
| strap_phy | input | 5 | Strapped PHY address |
| strap_iso_def | input | 1 | Reset default of the isolate bit |
| pin_pdown | input | 1 | Power-down request pin |
| pin_iso | input | 1 | Isolate request pin |
| pin_bypass | input | 1 | Coding-bypass request pin |
| mode_100 | input | 1 | High when the 100 Mb/s mode is selected |
| data_oe_req | input | 8 | Output enables requested by the data interface |
| mdio_in | input | 1 | Management data line as received |
| mdio_out | output | 1 | Value driven on the management line |
| mdio_oe | output | 1 | Enable for driving the management line |
| chip_reset | output | 1 | Chip-level reset, active high |
| pdown | output | 1 | Effective power-down |
| iso | output | 1 | Effective isolate |
| bypass | output | 1 | Effective coding bypass |
| data_oe | output | 8 | Data-interface output enables after isolation |

## Verification
Most internal faults in the frame decoder appear at the line within one frame. A wrong bit counter or state shifts the turnaround by a clock, or shifts the read data by one bit position. A wrong address or opcode decision shows up as a drive or a write where none belongs, and it is visible by the following read-back. A fault in the reset sequencer shows up as `chip_reset` lasting the wrong number of clocks, or as bit 15 or the isolate default reading wrong right after the sequence ends. A fault in a register bit shows up on the same clock in `pdown`, `iso`, `bypass` or `data_oe`.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    typedef enum logic [2:0] {
        FR_PRE,
        FR_START,
        FR_OP,
        FR_PHY,
        FR_REG,
        FR_TA1,
        FR_TA2,
        FR_DATA
    } frame_state_t;

    typedef enum logic {
        RS_BUSY,
        RS_READY
    } rst_state_t;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  strap_phy,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [REG_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int PRE_CW = $clog2(PRE_LEN + 1);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [PRE_CW-1:0] PRE_MAX  = PRE_CW'(PRE_LEN);
    localparam logic [CNT_W-1:0]  PHY_LAST = CNT_W'(PHY_W - 1);
    localparam logic [CNT_W-1:0]  REG_LAST = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0]  DAT_LAST = CNT_W'(DATA_W - 1);

    frame_state_t        state_q, state_d;
    logic [PRE_CW-1:0]   pre_q, pre_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                rd_q, rd_d;
    logic                hit_q, hit_d;
    logic [PHY_W-1:0]    phy_q, phy_d;
    logic [REG_W-1:0]    reg_q, reg_d;
    logic [DATA_W-1:0]   sh_q, sh_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        pre_d   = pre_q;
        cnt_d   = cnt_q;
        rd_d    = rd_q;
        hit_d   = hit_q;
        phy_d   = phy_q;
        reg_d   = reg_q;
        sh_d    = sh_q;
        unique case (state_q)
            FR_PRE: begin
                if (mdio_in) begin
                    if (pre_q != PRE_MAX) pre_d = pre_q + 1'b1;
                end else begin
                    if (pre_q == PRE_MAX) state_d = FR_START;
                    pre_d = '0;
                end
            end
            FR_START: begin
                cnt_d   = '0;
                state_d = mdio_in ? FR_OP : FR_PRE;
            end
            FR_OP: begin
                sh_d  = {sh_q[DATA_W-2:0], mdio_in};
                cnt_d = cnt_q + 1'b1;
                if (cnt_q != '0) begin
                    cnt_d = '0;
                    if ({sh_q[0], mdio_in} == OP_READ) begin
                        rd_d    = 1'b1;
                        state_d = FR_PHY;
                    end else if ({sh_q[0], mdio_in} == OP_WRITE) begin
                        rd_d    = 1'b0;
                        state_d = FR_PHY;
                    end else begin
                        state_d = FR_PRE;
                    end
                end
            end
            FR_PHY: begin
                phy_d = {phy_q[PHY_W-2:0], mdio_in};
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == PHY_LAST) begin
                    cnt_d   = '0;
                    state_d = FR_REG;
                end
            end
            FR_REG: begin
                reg_d = {reg_q[REG_W-2:0], mdio_in};
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == REG_LAST) begin
                    cnt_d   = '0;
                    hit_d   = (phy_q == strap_phy) || (phy_q == '0);
                    state_d = FR_TA1;
                end
            end
            FR_TA1: state_d = FR_TA2;
            FR_TA2: begin
                sh_d    = rd_data;
                cnt_d   = '0;
                state_d = FR_DATA;
            end
            FR_DATA: begin
                sh_d  = {sh_q[DATA_W-2:0], mdio_in};
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == DAT_LAST) begin
                    cnt_d   = '0;
                    pre_d   = '0;
                    state_d = FR_PRE;
                end
            end
            default: state_d = FR_PRE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_PRE;
            pre_q   <= '0;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            hit_q   <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            cnt_q   <= cnt_d;
            rd_q    <= rd_d;
            hit_q   <= hit_d;
            phy_q   <= phy_d;
            reg_q   <= reg_d;
            sh_q    <= sh_d;
        end
    end

    // outputs
    always_comb begin
        mdio_oe  = 1'b0;
        mdio_out = 1'b0;
        wr_en    = 1'b0;
        rd_addr  = reg_q;
        wr_addr  = reg_q;
        wr_data  = {sh_q[DATA_W-2:0], mdio_in};
        unique case (state_q)
            FR_TA2:  mdio_oe = rd_q && hit_q;
            FR_DATA: begin
                mdio_oe  = rd_q && hit_q;
                mdio_out = rd_q && hit_q && sh_q[DATA_W-1];
                wr_en    = !rd_q && hit_q && (cnt_q == DAT_LAST);
            end
            default: ;
        endcase
    end

    // R3: the drive starts with a zero turnaround bit
    assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R3: data leaves MSB first, one bit per clock
    assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_DATA && $past(state_q) == FR_DATA && mdio_oe)
        |-> mdio_out == $past(sh_q[DATA_W-2]));

endmodule

// File: rtl/mgmt_ctrl_regs.sv
module mgmt_ctrl_regs
    import mgmt_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int CTRL_ADDR  = 0,
    parameter int VEND_ADDR  = 16,
    parameter int RST_BIT    = 15,
    parameter int ISO_BIT    = 10,
    parameter int RST_CYCLES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_iso_def,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] vend_q,
    output logic              busy
);

    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [RC_W-1:0]  RC_LOAD = RC_W'(RST_CYCLES);
    localparam logic [REG_W-1:0] A_CTRL  = REG_W'(CTRL_ADDR);
    localparam logic [REG_W-1:0] A_VEND  = REG_W'(VEND_ADDR);

    rst_state_t       rs_q, rs_d;
    logic [RC_W-1:0]  rc_q, rc_d;
    logic [DATA_W-1:0] ctrl_d, vend_d, ctrl_def, rst_mask;

    always_comb begin
        ctrl_def          = '0;
        ctrl_def[ISO_BIT] = strap_iso_def;
        rst_mask          = '0;
        rst_mask[RST_BIT] = 1'b1;
    end

    // next-state logic
    always_comb begin
        rs_d   = rs_q;
        rc_d   = rc_q;
        ctrl_d = ctrl_q;
        vend_d = vend_q;
        unique case (rs_q)
            RS_BUSY: begin
                ctrl_d = ctrl_def;
                vend_d = '0;
                rc_d   = rc_q - 1'b1;
                if (rc_q <= RC_W'(1)) begin
                    rc_d = '0;
                    rs_d = RS_READY;
                end
            end
            RS_READY: begin
                if (wr_en && wr_addr == A_CTRL) begin
                    if (wr_data[RST_BIT]) begin
                        rs_d = RS_BUSY;
                        rc_d = RC_LOAD;
                    end else begin
                        ctrl_d = wr_data & ~rst_mask;
                    end
                end else if (wr_en && wr_addr == A_VEND) begin
                    vend_d = wr_data;
                end
            end
            default: rs_d = RS_BUSY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q   <= RS_BUSY;
            rc_q   <= RC_LOAD;
            ctrl_q <= '0;
            vend_q <= '0;
        end else begin
            rs_q   <= rs_d;
            rc_q   <= rc_d;
            ctrl_q <= ctrl_d;
            vend_q <= vend_d;
        end
    end

    // outputs
    always_comb begin
        busy = (rs_q == RS_BUSY);
        if (rd_addr == A_CTRL)      rd_data = ctrl_q | (busy ? rst_mask : '0);
        else if (rd_addr == A_VEND) rd_data = vend_q;
        else                        rd_data = '0;
    end

    // R6: a reset-bit write starts the sequence on the next clock
    assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && wr_data[RST_BIT] && !busy) |=> busy);

    // R7: isolate default taken from the strap when the sequence ends
    assert_iso_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ctrl_q[ISO_BIT] == $past(strap_iso_def));

    // R5: writes elsewhere leave both registers alone
    assert_unimpl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr != A_CTRL && wr_addr != A_VEND)
        |=> $stable(ctrl_q) && $stable(vend_q));

endmodule

// File: rtl/mgmt_ctrl_slave.sv
module mgmt_ctrl_slave
    import mgmt_pkg::*;
#(
    parameter int PHY_W      = 5,
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int PRE_LEN    = 32,
    parameter int RST_CYCLES = 80,
    parameter int DOE_W      = 8,
    parameter int CTRL_ADDR  = 0,
    parameter int VEND_ADDR  = 16,
    parameter int RST_BIT    = 15,
    parameter int PDN_BIT    = 11,
    parameter int ISO_BIT    = 10,
    parameter int BYP_BIT    = 1
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic [PHY_W-1:0] strap_phy,
    input  logic             strap_iso_def,
    input  logic             pin_pdown,
    input  logic             pin_iso,
    input  logic             pin_bypass,
    input  logic             mode_100,
    input  logic [DOE_W-1:0] data_oe_req,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             chip_reset,
    output logic             pdown,
    output logic             iso,
    output logic             bypass,
    output logic [DOE_W-1:0] data_oe
);

    logic [REG_W-1:0]  rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data, ctrl_q, vend_q;
    logic              wr_en, busy;

    mgmt_frame_fsm #(
        .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)
    ) u_frame (
        .clk(mdc), .rst_n(rst_n), .strap_phy(strap_phy),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    mgmt_ctrl_regs #(
        .REG_W(REG_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
        .VEND_ADDR(VEND_ADDR), .RST_BIT(RST_BIT), .ISO_BIT(ISO_BIT),
        .RST_CYCLES(RST_CYCLES)
    ) u_regs (
        .clk(mdc), .rst_n(rst_n), .strap_iso_def(strap_iso_def),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_q(ctrl_q), .vend_q(vend_q), .busy(busy)
    );

    always_comb begin
        chip_reset = busy;
        pdown      = ctrl_q[PDN_BIT] | pin_pdown;
        iso        = ctrl_q[ISO_BIT] | pin_iso;
        bypass     = (vend_q[BYP_BIT] | pin_bypass) & mode_100;
    end

    for (genvar g = 0; g < DOE_W; g++) begin : g_doe
        assign data_oe[g] = data_oe_req[g] & ~iso;
    end

    assert_pin_pdown_R8: assert property (@(posedge mdc) disable iff (!rst_n)
        pin_pdown |-> pdown);

    assert_pin_iso_R9: assert property (@(posedge mdc) disable iff (!rst_n)
        pin_iso |-> iso);

    assert_iso_hiz_R9: assert property (@(posedge mdc) disable iff (!rst_n)
        iso |-> data_oe == '0);

    assert_bypass_gate_R10: assert property (@(posedge mdc) disable iff (!rst_n)
        !mode_100 |-> !bypass);

endmodule

// File: tb/mgmt_ctrl_slave_test.sv
module mgmt_ctrl_slave_test;

    localparam int RC = 80;
    localparam logic [4:0] MY_PHY    = 5'b00101;
    localparam logic [4:0] OTHER_PHY = 5'b10010;

    logic       mdc = 1'b0;
    logic       rst_n, strap_iso_def, pin_pdown, pin_iso, pin_bypass, mode_100;
    logic [4:0] strap_phy;
    logic [7:0] data_oe_req, data_oe;
    logic       mdio_in, mdio_out, mdio_oe, chip_reset, pdown, iso, bypass;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_ctrl, m_vend;

    always #2 mdc = ~mdc;

    mgmt_ctrl_slave #(.RST_CYCLES(RC)) uut (
        .mdc(mdc), .rst_n(rst_n), .strap_phy(strap_phy),
        .strap_iso_def(strap_iso_def), .pin_pdown(pin_pdown),
        .pin_iso(pin_iso), .pin_bypass(pin_bypass), .mode_100(mode_100),
        .data_oe_req(data_oe_req), .mdio_in(mdio_in), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .chip_reset(chip_reset), .pdown(pdown),
        .iso(iso), .bypass(bypass), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] ra);
        if (ra == 5'd0)       return m_ctrl;
        else if (ra == 5'd16) return m_vend;
        else                  return 16'h0000;
    endfunction

    function automatic bit phy_hit(input logic [4:0] p);
        return (p == strap_phy) || (p == 5'd0);
    endfunction

    task automatic drive_bit(input logic b);
        @(negedge mdc);
        mdio_in = b;
    endtask

    task automatic send_head(input int pre, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) drive_bit(1'b1);
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(op[1]);
        drive_bit(op[0]);
        for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
        for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
    endtask

    task automatic raw_write(input int pre, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] d);
        send_head(pre, op, phy, ra);
        drive_bit(1'b1);
        drive_bit(1'b0);
        for (int i = 15; i >= 0; i--) drive_bit(d[i]);
        @(negedge mdc);
        mdio_in = 1'b1;
    endtask

    task automatic mgmt_write(input logic [4:0] phy, input logic [4:0] ra,
                              input logic [15:0] d);
        raw_write(32, 2'b01, phy, ra, d);
    endtask

    task automatic mgmt_read(input logic [4:0] phy, input logic [4:0] ra,
                             output logic [15:0] d, output bit ta_ok, output bit any_oe);
        send_head(32, 2'b10, phy, ra);
        any_oe = 1'b0;
        @(negedge mdc);
        ta_ok  = !mdio_oe;
        any_oe = mdio_oe;
        mdio_in = 1'b1;
        @(negedge mdc);
        ta_ok  = ta_ok && mdio_oe && !mdio_out;
        any_oe = any_oe | mdio_oe;
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            d[i]   = mdio_out;
            any_oe = any_oe | mdio_oe;
            ta_ok  = ta_ok && mdio_oe;
        end
    endtask

    task automatic check_read(input logic [4:0] phy, input logic [4:0] ra, input string req);
        logic [15:0] d;
        bit ta_ok, any_oe;
        mgmt_read(phy, ra, d, ta_ok, any_oe);
        if (phy_hit(phy)) begin
            chk(ta_ok, {req, " R3 turnaround"}, {31'd0, ta_ok}, 32'd1);
            chk(d == exp_read(ra), req, {16'd0, d}, {16'd0, exp_read(ra)});
        end else begin
            chk(!any_oe, {req, " R2 no drive"}, {31'd0, any_oe}, 32'd0);
        end
    endtask

    task automatic check_pins(input string req);
        logic e_iso;
        #1;
        e_iso = m_ctrl[10] | pin_iso;
        chk(pdown == (m_ctrl[11] | pin_pdown), {req, " R8 pdown"}, {31'd0, pdown},
            {31'd0, m_ctrl[11] | pin_pdown});
        chk(iso == e_iso, {req, " R9 iso"}, {31'd0, iso}, {31'd0, e_iso});
        chk(data_oe == (e_iso ? 8'h00 : data_oe_req), {req, " R9 data_oe"},
            {24'd0, data_oe}, {24'd0, e_iso ? 8'h00 : data_oe_req});
        chk(bypass == ((m_ctrl[1] & 1'b0 | m_vend[1] | pin_bypass) & mode_100),
            {req, " R10 bypass"}, {31'd0, bypass},
            {31'd0, (m_vend[1] | pin_bypass) & mode_100});
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge mdc);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [4:0]  phy, ra;
        logic [15:0] d;
        int n;
        void'($urandom(32'd2024));
        rst_n = 1'b0; strap_iso_def = 1'b1; strap_phy = MY_PHY;
        pin_pdown = 1'b0; pin_iso = 1'b0; pin_bypass = 1'b0; mode_100 = 1'b0;
        data_oe_req = 8'hA5; mdio_in = 1'b1;
        repeat (3) @(negedge mdc);
        chk(chip_reset == 1'b1, "R6 reset pin holds chip_reset", {31'd0, chip_reset}, 32'd1);
        chk(mdio_oe == 1'b0, "R3 line released in reset", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (RC + 2) @(negedge mdc);
        chk(chip_reset == 1'b0, "R6 reset sequence ends", {31'd0, chip_reset}, 32'd0);
        m_ctrl = 16'h0400; m_vend = 16'h0000;
        check_pins("R7 iso default high");
        check_read(MY_PHY, 5'd0, "R7 control after reset");

        // R4: writes and readback
        mgmt_write(MY_PHY, 5'd0, 16'h0000); m_ctrl = 16'h0000;
        check_pins("R4 iso cleared");
        mgmt_write(MY_PHY, 5'd16, 16'hBEEF); m_vend = 16'hBEEF;
        check_read(MY_PHY, 5'd16, "R4 vendor readback");
        // R2: address zero always answers, other addresses never
        check_read(5'd0, 5'd16, "R2 broadcast read");
        check_read(OTHER_PHY, 5'd16, "R2 foreign read");
        mgmt_write(OTHER_PHY, 5'd16, 16'h1234);
        check_read(MY_PHY, 5'd16, "R2 foreign write ignored");
        mgmt_write(5'd0, 5'd16, 16'h0F0F); m_vend = 16'h0F0F;
        check_read(MY_PHY, 5'd16, "R2 broadcast write");
        // R5: unimplemented address
        mgmt_write(MY_PHY, 5'd5, 16'hFFFF);
        check_read(MY_PHY, 5'd5, "R5 unimplemented reads zero");
        check_read(MY_PHY, 5'd16, "R5 write elsewhere ignored");
        check_read(MY_PHY, 5'd0, "R5 control untouched");
        // R1: short preamble and bad opcode
        raw_write(31, 2'b01, MY_PHY, 5'd16, 16'h5555);
        check_read(MY_PHY, 5'd16, "R1 short preamble ignored");
        raw_write(32, 2'b11, MY_PHY, 5'd16, 16'h3333);
        check_read(MY_PHY, 5'd16, "R1 bad opcode ignored");
        // R10: bypass gating
        mgmt_write(MY_PHY, 5'd16, 16'h0002); m_vend = 16'h0002;
        check_pins("R10 bypass without 100 mode");
        mode_100 = 1'b1;
        check_pins("R10 bypass register");
        mgmt_write(MY_PHY, 5'd16, 16'h0000); m_vend = 16'h0000;
        pin_bypass = 1'b1;
        check_pins("R10 bypass pin");
        // R11: management while powered down and isolated
        pin_pdown = 1'b1; pin_iso = 1'b1;
        check_pins("R9 pins forced");
        mgmt_write(MY_PHY, 5'd0, 16'h0C00); m_ctrl = 16'h0C00;
        check_read(MY_PHY, 5'd0, "R11 access in pdown and iso");
        pin_pdown = 1'b0; pin_iso = 1'b0;
        check_pins("R8 R9 register bits alone");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int sel;
            sel = int'($urandom_range(0, 2));
            phy = (sel == 0) ? MY_PHY : (sel == 1) ? 5'd0 : OTHER_PHY;
            sel = int'($urandom_range(0, 2));
            ra  = (sel == 0) ? 5'd0 : (sel == 1) ? 5'd16 : 5'($urandom);
            d   = 16'($urandom) & 16'h7FFF;
            if ($urandom_range(0, 1) == 1) begin
                mgmt_write(phy, ra, d);
                if (phy_hit(phy) && ra == 5'd0)  m_ctrl = d;
                if (phy_hit(phy) && ra == 5'd16) m_vend = d;
            end else begin
                check_read(phy, ra, "R4 R5 random read");
            end
            pin_pdown = 1'($urandom); pin_iso = 1'($urandom);
            pin_bypass = 1'($urandom); mode_100 = 1'($urandom);
            data_oe_req = 8'($urandom);
            check_pins("R8 R9 R10 random pins");
        end
        pin_pdown = 1'b0; pin_iso = 1'b0; pin_bypass = 1'b0;

        // R6 soft reset length, R7 strap low
        strap_iso_def = 1'b0;
        mgmt_write(MY_PHY, 5'd16, 16'h00FF);
        raw_write(32, 2'b01, MY_PHY, 5'd0, 16'h8800);
        n = 1;
        for (int j = 0; j < RC + 5; j++) begin
            @(negedge mdc);
            if (chip_reset) n++;
        end
        chk(n == RC, "R6 soft reset length", n, RC);
        m_ctrl = 16'h0000; m_vend = 16'h0000;
        check_pins("R7 iso default low");
        check_read(MY_PHY, 5'd0, "R6 R7 control after soft reset");
        check_read(MY_PHY, 5'd16, "R6 vendor cleared");

        // R6 reset bit reads one while running
        mgmt_write(MY_PHY, 5'd0, 16'h8000);
        m_ctrl = 16'h8000;
        check_read(MY_PHY, 5'd0, "R6 reset bit busy");
        repeat (RC) @(negedge mdc);
        m_ctrl = 16'h0000;
        check_read(MY_PHY, 5'd0, "R6 reset bit self-clears");
        finish_run();
    end

endmodule